// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer (Core Side)

This block sits in a processor's Execute stage and runs the core's side of the handshake with an external coprocessor. When a coprocessor instruction is accepted into Execute, the block checks the instruction's condition field against the NZCV flags. It then samples a two-bit response from the coprocessor and decides what happens next. The instruction may busy-wait, run another execute cycle, finish, raise the undefined-instruction trap, or retire as a no-op when its condition fails.

Two response buses are provided. One carries the answer for an instruction that is entering Execute. The other carries the answer for an instruction that is already executing and needs more cycles. The block picks between them according to its own state. Towards the coprocessor it drives a pass strobe and a late-cancel strobe. Towards the pipeline it drives a stall and a trap request. An interrupt that arrives while the instruction busy-waits abandons the coprocessor instruction.

An instruction is accepted on a rising edge where `core_stall` is low and both `instr_valid` and `instr_is_cp` are high. The instruction fields, the flags, `prev_dabort` and the decode-phase response are sampled on that same edge.

Top module: `cpx_handshake_seq`

## Requirements
- R1: The condition test covers all 16 codes, with flags[3]=N, flags[2]=Z, flags[1]=C and flags[0]=V. 0 passes on Z. 1 passes on !Z. 2 passes on C. 3 passes on !C. 4 passes on N. 5 passes on !N. 6 passes on V. 7 passes on !V. 8 passes on C&!Z. 9 passes on !C|Z. 10 passes on N==V. 11 passes on N!=V. 12 passes on !Z&(N==V). 13 passes on Z|(N!=V). 14 always passes. 15 never passes with the default parameters.
- R2: `cp_pass` is high in every Execute cycle of an accepted coprocessor instruction whose condition passed, and low in all other cycles.
- R3: An accepted instruction whose condition fails retires as a no-op, whatever the response. In the following cycle there is no pass, no trap and no stall.
- R4: Responses are encoded as WAIT=2'b00, GO=2'b01, ABSENT=2'b10 and LAST=2'b11. Sampling ABSENT for a passed instruction raises `undef_trap` for exactly the next cycle, with stall and pass low. This applies on either bus.
- R5: A WAIT response holds `core_stall` and `cp_pass` high in every following cycle until a response other than WAIT is sampled.
- R6: An interrupt during a busy-wait cycle drives `cp_pass` and `core_stall` low in that same cycle. The instruction is then abandoned at the next edge, with no trap whatever the response. An interrupt during a GO cycle has no effect.
- R7: A GO response gives a further Execute cycle with stall and pass high. A LAST response gives one final Execute cycle with pass high and stall low, after which the instruction retires.
- R8: The decode-phase bus is used only on an edge that can accept a new instruction. While the block stalls, only the execute-phase bus is used, and instructions offered at the input are ignored.
- R9: `cp_late_cancel` is high only in the cycle after the first Execute cycle of a passed, non-ABSENT instruction, and only when `prev_dabort` was high at its acceptance. This holds even when a second instruction follows back to back.
- R10: An offer that has `instr_valid` or `instr_is_cp` low changes no output.
- R11: While reset is asserted and in the first cycle after it is released, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is offered for Execute |
| instr_is_cp | input | 1 | The offered instruction is a coprocessor instruction |
| instr_cond | input | COND_W | Condition field of the offered instruction |
| flags_nzcv | input | FLAG_W | Current flags, N Z C V from MSB to LSB |
| prev_dabort | input | 1 | The preceding instruction caused a data abort |
| irq | input | 1 | Interrupt request |
| cp_rsp_dec | input | RESP_W | Coprocessor response for an entering instruction |
| cp_rsp_exe | input | RESP_W | Coprocessor response for a continuing instruction |
| core_stall | output | 1 | Holds the pipeline; no new instruction can enter |
| undef_trap | output | 1 | One-cycle undefined-instruction trap request |
| cp_pass | output | 1 | The instruction in Execute is a coprocessor instruction and passed its condition |
| cp_late_cancel | output | 1 | Cancels the instruction because its predecessor aborted |

## Verification
A wrong state register appears at the ports within one cycle, because stall and pass are decoded directly from the state. A stuck busy-wait leaves `core_stall` high after a LAST response. A state that fails to leave idle drops `cp_pass` in the first Execute cycle. A wrong bus selection shows up one edge later, as a trap or stall that should not occur when the unused bus carries ABSENT. Late-cancel errors are visible exactly two cycles after acceptance, and the back-to-back case separates them from errors in the following instruction.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

   typedef enum logic [1:0] {
      RSP_WAIT   = 2'b00,
      RSP_GO     = 2'b01,
      RSP_ABSENT = 2'b10,
      RSP_LAST   = 2'b11
   } rsp_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_EXEC = 2'd2,
      ST_LAST = 2'd3
   } st_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

endpackage

// File: rtl/cpx_cond_eval.sv
module cpx_cond_eval #(
   parameter int COND_W    = 4,
   parameter int FLAG_W    = 4,
   parameter bit NV_PASSES = 1'b0
) (
   input  logic [COND_W-1:0] cond,
   input  logic [FLAG_W-1:0] flags,
   output logic              ok
);
   import cpx_pkg::*;

   localparam int NUM_CODES = 1 << COND_W;

   if (COND_W != 4) begin : g_bad_cond
      $error("cpx_cond_eval: COND_W must be 4");
   end
   if (FLAG_W != 4) begin : g_bad_flag
      $error("cpx_cond_eval: FLAG_W must be 4");
   end

   logic f_n, f_z, f_c, f_v;
   logic nv_result;
   logic [NUM_CODES-1:0] code_ok;

   assign f_n = flags[FLG_N];
   assign f_z = flags[FLG_Z];
   assign f_c = flags[FLG_C];
   assign f_v = flags[FLG_V];

   generate
      if (NV_PASSES) begin : g_nv_always
         assign nv_result = 1'b1;
      end else begin : g_nv_never
         assign nv_result = 1'b0;
      end
   endgenerate

   always_comb begin
      code_ok[0]  = f_z;
      code_ok[1]  = !f_z;
      code_ok[2]  = f_c;
      code_ok[3]  = !f_c;
      code_ok[4]  = f_n;
      code_ok[5]  = !f_n;
      code_ok[6]  = f_v;
      code_ok[7]  = !f_v;
      code_ok[8]  = f_c && !f_z;
      code_ok[9]  = !f_c || f_z;
      code_ok[10] = (f_n == f_v);
      code_ok[11] = (f_n != f_v);
      code_ok[12] = !f_z && (f_n == f_v);
      code_ok[13] = f_z || (f_n != f_v);
      code_ok[14] = 1'b1;
      code_ok[15] = nv_result;
   end

   assign ok = code_ok[cond];

endmodule

// File: rtl/cpx_resp_sel.sv
module cpx_resp_sel #(
   parameter int RESP_W = 2
) (
   input  logic              use_exe,
   input  logic [RESP_W-1:0] rsp_dec,
   input  logic [RESP_W-1:0] rsp_exe,
   output logic [RESP_W-1:0] rsp
);
   if (RESP_W != 2) begin : g_bad_resp
      $error("cpx_resp_sel: RESP_W must be 2");
   end

   assign rsp = use_exe ? rsp_exe : rsp_dec;

endmodule

// File: rtl/cpx_hs_fsm.sv
module cpx_hs_fsm #(
   parameter int RESP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              offer_cp,
   input  logic              cond_ok,
   input  logic              prev_dabort,
   input  logic              irq,
   input  logic [RESP_W-1:0] rsp_in,
   output logic              use_exe,
   output logic              stall,
   output logic              undef_trap,
   output logic              cp_pass,
   output logic              late_cancel
);
   import cpx_pkg::*;

   st_e  st_q, st_d;
   rsp_e rsp;
   logic abandon, busy, accept, sample, trap_d, trap_q, first_d, first_q, lc_q;

   assign rsp     = rsp_e'(rsp_in);
   assign busy    = (st_q == ST_WAIT) || (st_q == ST_EXEC);
   assign abandon = (st_q == ST_WAIT) && irq;
   assign stall   = busy && !abandon;
   assign use_exe = stall;
   assign cp_pass = (st_q != ST_IDLE) && !abandon;
   assign accept  = !stall && offer_cp;
   assign sample  = stall || (accept && cond_ok);

   always_comb begin
      st_d = ST_IDLE;
      if (sample) begin
         unique case (rsp)
            RSP_WAIT:   st_d = ST_WAIT;
            RSP_GO:     st_d = ST_EXEC;
            RSP_LAST:   st_d = ST_LAST;
            RSP_ABSENT: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
         endcase
      end
   end

   assign trap_d  = sample && (rsp == RSP_ABSENT);
   assign first_d = accept && cond_ok && (rsp != RSP_ABSENT) && prev_dabort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         trap_q  <= 1'b0;
         first_q <= 1'b0;
         lc_q    <= 1'b0;
      end else begin
         st_q    <= st_d;
         trap_q  <= trap_d;
         first_q <= first_d;
         lc_q    <= first_q;
      end
   end

   assign undef_trap  = trap_q;
   assign late_cancel = lc_q;

   assert_fail_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cond_ok) |=> (!cp_pass && !undef_trap && !stall));

   assert_trap_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      undef_trap |-> (!stall && !cp_pass));

   assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && rsp == RSP_WAIT) |=> (cp_pass || irq));

   assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && irq) |-> (!cp_pass && !stall));

   assert_irq_no_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && irq) |=> !undef_trap);

   assert_last_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && rsp == RSP_LAST) |=> (cp_pass && !stall));

   assert_lc_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      late_cancel |-> $past(st_q != ST_IDLE));

endmodule

// File: rtl/cpx_handshake_seq.sv
module cpx_handshake_seq #(
   parameter int COND_W    = 4,
   parameter int FLAG_W    = 4,
   parameter int RESP_W    = 2,
   parameter bit NV_PASSES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic              instr_is_cp,
   input  logic [COND_W-1:0] instr_cond,
   input  logic [FLAG_W-1:0] flags_nzcv,
   input  logic              prev_dabort,
   input  logic              irq,
   input  logic [RESP_W-1:0] cp_rsp_dec,
   input  logic [RESP_W-1:0] cp_rsp_exe,
   output logic              core_stall,
   output logic              undef_trap,
   output logic              cp_pass,
   output logic              cp_late_cancel
);
   logic              cond_ok;
   logic              use_exe;
   logic [RESP_W-1:0] rsp_sel;
   logic              offer_cp;

   assign offer_cp = instr_valid && instr_is_cp;

   cpx_cond_eval #(
      .COND_W    (COND_W),
      .FLAG_W    (FLAG_W),
      .NV_PASSES (NV_PASSES)
   ) u_cond (
      .cond  (instr_cond),
      .flags (flags_nzcv),
      .ok    (cond_ok)
   );

   cpx_resp_sel #(
      .RESP_W (RESP_W)
   ) u_sel (
      .use_exe (use_exe),
      .rsp_dec (cp_rsp_dec),
      .rsp_exe (cp_rsp_exe),
      .rsp     (rsp_sel)
   );

   cpx_hs_fsm #(
      .RESP_W (RESP_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .offer_cp    (offer_cp),
      .cond_ok     (cond_ok),
      .prev_dabort (prev_dabort),
      .irq         (irq),
      .rsp_in      (rsp_sel),
      .use_exe     (use_exe),
      .stall       (core_stall),
      .undef_trap  (undef_trap),
      .cp_pass     (cp_pass),
      .late_cancel (cp_late_cancel)
   );

   assert_pass_needs_cp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_stall && cp_pass) |-> $past(offer_cp || core_stall));

endmodule

// File: tb/sim_cpx_handshake_seq.sv
module sim_cpx_handshake_seq;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] W = 2'b00, G = 2'b01, A = 2'b10, L = 2'b11;
   localparam logic [3:0] AL = 4'd14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic instr_valid = 1'b0, instr_is_cp = 1'b0, prev_dabort = 1'b0, irq = 1'b0;
   logic [3:0] instr_cond = 4'd0, flags_nzcv = 4'd0;
   logic [1:0] cp_rsp_dec = A, cp_rsp_exe = A;
   logic core_stall, undef_trap, cp_pass, cp_late_cancel;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cpx_handshake_seq u0 (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_is_cp(instr_is_cp),
      .instr_cond(instr_cond), .flags_nzcv(flags_nzcv), .prev_dabort(prev_dabort),
      .irq(irq), .cp_rsp_dec(cp_rsp_dec), .cp_rsp_exe(cp_rsp_exe),
      .core_stall(core_stall), .undef_trap(undef_trap), .cp_pass(cp_pass),
      .cp_late_cancel(cp_late_cancel)
   );

   // Expected outputs per cycle, packed as {stall, trap, pass, late_cancel}
   task automatic cyc(input logic v, input logic cp, input logic [3:0] c, input logic [3:0] f,
                      input logic dab, input logic iq, input logic [1:0] rd, input logic [1:0] re,
                      input logic [3:0] e, input string t);
      @(negedge clk);
      instr_valid = v; instr_is_cp = cp; instr_cond = c; flags_nzcv = f;
      prev_dabort = dab; irq = iq; cp_rsp_dec = rd; cp_rsp_exe = re;
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic idle(input logic [1:0] re, input logic iq, input logic [3:0] e, input string t);
      cyc(1'b0, 1'b0, AL, 4'd0, 1'b0, iq, A, re, e, t);
   endtask

   task automatic offer(input logic [3:0] c, input logic [3:0] f, input logic dab,
                        input logic [1:0] rd, input logic [3:0] e, input string t);
      cyc(1'b1, 1'b1, c, f, dab, 1'b0, rd, A, e, t);
   endtask

   function automatic logic cond_ref(input logic [3:0] c, input logic [3:0] f);
      logic n, z, cf, v;
      {n, z, cf, v} = f;
      case (c)
         4'd0:  return z;
         4'd1:  return !z;
         4'd2:  return cf;
         4'd3:  return !cf;
         4'd4:  return n;
         4'd5:  return !n;
         4'd6:  return v;
         4'd7:  return !v;
         4'd8:  return cf && !z;
         4'd9:  return !cf || z;
         4'd10: return n == v;
         4'd11: return n != v;
         4'd12: return !z && (n == v);
         4'd13: return z || (n != v);
         4'd14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // Monitor: pops one expectation per cycle and compares
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [3:0] e;
            logic [3:0] act;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {core_stall, undef_trap, cp_pass, cp_late_cancel};
            n_cmp++;
            if (act !== e) begin
               n_bad++;
               $display("FAIL %s actual=%b expected=%b", t, act, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired before all R checks completed");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R11 reset
      idle(A, 1'b0, 4'b0000, "R11 in reset");
      idle(A, 1'b0, 4'b0000, "R11 in reset");
      rst_n = 1'b1;
      idle(A, 1'b0, 4'b0000, "R11 after reset");

      // R7 LAST at entry, R2 pass only in the execute cycle
      offer(AL, 4'd0, 1'b0, L, 4'b0000, "R2 offer LAST");
      idle(A, 1'b0, 4'b0010, "R7 final cycle pass no stall");
      idle(A, 1'b0, 4'b0000, "R2 pass gone after retire");

      // R3 condition fails (EQ with Z clear), response ABSENT
      offer(4'd0, 4'b0000, 1'b1, A, 4'b0000, "R3 offer failing cond");
      idle(A, 1'b0, 4'b0000, "R3 no trap no pass no stall");
      idle(A, 1'b0, 4'b0000, "R3 no late cancel");

      // R4 ABSENT on decode bus
      offer(AL, 4'd0, 1'b0, A, 4'b0000, "R4 offer ABSENT");
      idle(A, 1'b0, 4'b0100, "R4 trap pulse");
      idle(A, 1'b0, 4'b0000, "R4 trap single cycle");

      // R7 GO/LAST, R8 decode bus ignored while stalled, R9 late cancel
      offer(AL, 4'd0, 1'b1, G, 4'b0000, "R7 offer GO with abort");
      cyc(1'b1, 1'b1, AL, 4'd0, 1'b0, 1'b0, A, G, 4'b1010, "R8 stalled, dec ABSENT ignored");
      idle(L, 1'b0, 4'b1011, "R9 late cancel in second cycle");
      idle(A, 1'b0, 4'b0010, "R7 final execute cycle");
      idle(A, 1'b0, 4'b0000, "R7 retired");

      // R5 busy-wait
      offer(AL, 4'd0, 1'b0, W, 4'b0000, "R5 offer WAIT");
      idle(W, 1'b0, 4'b1010, "R5 waiting 1");
      idle(W, 1'b0, 4'b1010, "R5 waiting 2");
      idle(L, 1'b0, 4'b1010, "R5 waiting 3");
      idle(A, 1'b0, 4'b0010, "R5 final after wait");
      idle(A, 1'b0, 4'b0000, "R5 retired");

      // R6 interrupt during busy-wait
      offer(AL, 4'd0, 1'b0, W, 4'b0000, "R6 offer WAIT");
      idle(W, 1'b0, 4'b1010, "R6 waiting");
      idle(A, 1'b1, 4'b0000, "R6 irq drops pass and stall");
      idle(A, 1'b0, 4'b0000, "R6 abandoned without trap");

      // R6 interrupt during GO has no effect
      offer(AL, 4'd0, 1'b0, G, 4'b0000, "R6 offer GO");
      idle(L, 1'b1, 4'b1010, "R6 irq ignored in GO cycle");
      idle(A, 1'b0, 4'b0010, "R6 final cycle");
      idle(A, 1'b0, 4'b0000, "R6 retired");

      // R4 ABSENT on the execute bus
      offer(AL, 4'd0, 1'b0, G, 4'b0000, "R4 offer GO");
      idle(A, 1'b0, 4'b1010, "R4 exe bus ABSENT sampled");
      idle(A, 1'b0, 4'b0100, "R4 trap from exe bus");
      idle(A, 1'b0, 4'b0000, "R4 trap cleared");

      // R10 non-coprocessor and invalid offers
      cyc(1'b1, 1'b0, AL, 4'd0, 1'b1, 1'b0, A, A, 4'b0000, "R10 non-cp offer");
      cyc(1'b0, 1'b1, AL, 4'd0, 1'b1, 1'b0, A, A, 4'b0000, "R10 invalid offer");
      idle(A, 1'b0, 4'b0000, "R10 nothing happened");
      idle(A, 1'b0, 4'b0000, "R10 no late cancel");

      // R9 back-to-back LAST instructions, only the first had an abort
      offer(AL, 4'd0, 1'b1, L, 4'b0000, "R9 first offer");
      offer(AL, 4'd0, 1'b0, L, 4'b0010, "R9 second offer during final");
      idle(A, 1'b0, 4'b0011, "R9 cancel belongs to first");
      idle(A, 1'b0, 4'b0000, "R9 none for second");

      // R1 full condition table
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            offer(4'(c), 4'(f), 1'b0, L, 4'b0000, $sformatf("R1 offer code=%0d", c));
            idle(A, 1'b0, {2'b00, cond_ref(4'(c), 4'(f)), 1'b0},
                 $sformatf("R1 code=%0d flags=%b", c, 4'(f)));
         end
      end

      idle(A, 1'b0, 4'b0000, "R2 quiet at end");
      @(negedge clk);
      #5;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule